// File: doc/BRIEF.md
# Pulse-Interval Gap Write Decoder

This block turns the reader-to-tag write stream of a field-powered tag into bits. The reader sends data by briefly switching its field off; each such field gap is seen here as a high level on `gap_in`, which is asynchronous to the field clock and is resynchronized inside the block. A frame opens with a start gap of acceptable length. Every later gap closes an interval. The interval runs from the end of the previous gap to the end of the current one, measured in field clocks. Its length gives a "0", a "1" or an error. The windows differ between normal and fast write timing. The frame closes when the field stays on for longer than a mode-dependent silence limit.

The control is a four-state machine. IDLE waits for a gap while `cfg_ready` is high (IDLE to START). START counts the length of the start gap. When the gap ends it returns to IDLE if the length was out of range, or moves to SPACE and raises `sof` if the length was good. SPACE counts field-on clocks since the last gap end. A new gap moves it to GAP; a silence timeout moves it back to IDLE and raises `frame_end`. GAP counts the gap length while the interval count keeps running. When the gap ends it judges the interval and returns to SPACE. After the first bad interval, `err_flag` stays high and no further bits are strobed. The frame-end strobe carries that error status on `frame_err`.

Top module: `gap_write_decoder`

## Requirements
- R1: `gap_in` passes through a two-flop synchronizer, and the outputs are registered. When `gap_in` falls at the end of an accepted start gap, `sof` is high in the third clock cycle after the cycle in which the falling edge is first sampled.
- R2: A start gap is accepted only when it lasts 10 to 50 clocks inclusive. Acceptance gives a single one-cycle `sof` pulse. A start gap of any other length is dropped with no output.
- R3: While `cfg_ready` is low, gaps seen in IDLE are ignored and no frame starts.
- R4: In normal timing, an interval of 16 to 31 clocks yields a one-cycle `bit_valid` with `bit_data`=0, and an interval of 48 to 63 clocks yields `bit_valid` with `bit_data`=1. `bit_data` is 0 whenever `bit_valid` is 0.
- R5: In fast timing, an interval of 8 to 15 clocks gives bit 0 and 24 to 31 gives bit 1. The timing is taken from `fast_mode` at start-gap acceptance and held for the whole frame.
- R6: A write gap must last 8 to 30 clocks in normal timing and 8 to 20 in fast timing. A gap outside this range is an interval error.
- R7: An interval outside both bit windows is an error. The first error sets `err_flag`, which stays high until the frame ends. While `err_flag` is high, `bit_valid` stays low.
- R8: The frame ends when the field has stayed on for more than 64 clocks (normal) or more than 32 clocks (fast) since the end of the last gap. `frame_end` pulses for one cycle, `frame_err` equals the error status at that moment, and `err_flag` is cleared. A gap after exactly 64 (or 32) field-on clocks keeps the frame open.
- R9: The interval includes the closing gap's own length. For example, 40 field-on clocks followed by a 10-clock gap decodes as "1" in normal timing.
- R10: After reset, all outputs are 0 and the block waits in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ready | input | 1 | High once configuration is loaded; enables start-gap acceptance |
| fast_mode | input | 1 | 1 selects fast write timing, sampled at start-gap acceptance |
| gap_in | input | 1 | Asynchronous gap-detect level, 1 while the field is off |
| sof | output | 1 | One-cycle pulse when a start gap is accepted |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_data | output | 1 | Decoded bit value, 0 when `bit_valid` is low |
| frame_end | output | 1 | One-cycle pulse when the silence timeout closes the frame |
| frame_err | output | 1 | Error status of the frame, valid with `frame_end` |
| err_flag | output | 1 | High from the first interval error until the frame ends |

## Verification
A wrong state in this decoder shows up at the ports within one interval. A stale interval count shifts a window boundary, so a bit flips or an error appears at the next gap end. A lost error status makes `frame_err` disagree at the timeout. A miscounted silence makes `frame_end` arrive a cycle early or late, or makes a later gap start a frame that should not exist. A reference model built on timestamps is compared with all six outputs on every clock. Directed frames place intervals, gap lengths and silences exactly on each window edge and one clock beyond it, so an off-by-one error is seen at the first boundary it touches.

// File: rtl/gwd_pkg.sv
package gwd_pkg;

    localparam int CNT_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_SPACE,
        ST_GAP
    } gwd_state_e;

    typedef enum logic [1:0] {
        IV_BAD,
        IV_ZERO,
        IV_ONE
    } ivl_kind_e;

    typedef struct packed {
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
    } win_t;

    localparam win_t START_WIN  = '{lo: CNT_W'(10), hi: CNT_W'(50)};
    localparam win_t GAP_NORM   = '{lo: CNT_W'(8),  hi: CNT_W'(30)};
    localparam win_t GAP_FAST   = '{lo: CNT_W'(8),  hi: CNT_W'(20)};
    localparam win_t ZERO_NORM  = '{lo: CNT_W'(16), hi: CNT_W'(31)};
    localparam win_t ONE_NORM   = '{lo: CNT_W'(48), hi: CNT_W'(63)};
    localparam win_t ZERO_FAST  = '{lo: CNT_W'(8),  hi: CNT_W'(15)};
    localparam win_t ONE_FAST   = '{lo: CNT_W'(24), hi: CNT_W'(31)};

    localparam logic [CNT_W-1:0] SILENCE_NORM = CNT_W'(64);
    localparam logic [CNT_W-1:0] SILENCE_FAST = CNT_W'(32);

    function automatic logic in_win(input logic [CNT_W-1:0] v, input win_t w);
        return (v >= w.lo) && (v <= w.hi);
    endfunction

endpackage

// File: rtl/gwd_sync.sv
module gwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gwd_satcnt.sv
module gwd_satcnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_one,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_one) begin
            cnt <= W'(1);
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gwd_classify.sv
module gwd_classify
    import gwd_pkg::*;
(
    input  logic [CNT_W-1:0] gap_len,
    input  logic [CNT_W-1:0] ivl_len,
    input  logic             fast,
    output logic             gap_ok,
    output ivl_kind_e        kind
);
    win_t gw, w0, w1;

    always_comb begin
        gw = fast ? GAP_FAST  : GAP_NORM;
        w0 = fast ? ZERO_FAST : ZERO_NORM;
        w1 = fast ? ONE_FAST  : ONE_NORM;
        gap_ok = in_win(gap_len, gw);
        if (in_win(ivl_len, w0)) begin
            kind = IV_ZERO;
        end else if (in_win(ivl_len, w1)) begin
            kind = IV_ONE;
        end else begin
            kind = IV_BAD;
        end
    end
endmodule

// File: rtl/gap_write_decoder.sv
module gap_write_decoder
    import gwd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_ready,
    input  logic fast_mode,
    input  logic gap_in,
    output logic sof,
    output logic bit_valid,
    output logic bit_data,
    output logic frame_end,
    output logic frame_err,
    output logic err_flag
);
    gwd_state_e       st_q, st_d;
    logic             g;
    logic [CNT_W-1:0] glen, spc;
    logic             glen_load, glen_inc, spc_load, spc_inc;
    logic             gap_ok;
    ivl_kind_e        kind;
    logic             fast_q, err_q;
    logic             start_acc, ivl_done, ivl_bad, silence_end;
    logic [CNT_W-1:0] silence_lim;

    gwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(gap_in), .q(g)
    );

    gwd_satcnt #(.W(CNT_W)) u_gap_cnt (
        .clk(clk), .rst_n(rst_n), .load_one(glen_load), .inc(glen_inc), .cnt(glen)
    );

    gwd_satcnt #(.W(CNT_W)) u_ivl_cnt (
        .clk(clk), .rst_n(rst_n), .load_one(spc_load), .inc(spc_inc), .cnt(spc)
    );

    gwd_classify u_cls (
        .gap_len(glen), .ivl_len(spc), .fast(fast_q), .gap_ok(gap_ok), .kind(kind)
    );

    // Decision terms
    always_comb begin
        silence_lim = fast_q ? SILENCE_FAST : SILENCE_NORM;
        start_acc   = (st_q == ST_START) && !g && in_win(glen, START_WIN);
        ivl_done    = (st_q == ST_GAP) && !g;
        ivl_bad     = ivl_done && (!gap_ok || (kind == IV_BAD));
        silence_end = (st_q == ST_SPACE) && !g && (spc >= silence_lim);
        glen_load   = ((st_q == ST_IDLE) && g && cfg_ready) || ((st_q == ST_SPACE) && g);
        glen_inc    = ((st_q == ST_START) || (st_q == ST_GAP)) && g;
        spc_load    = start_acc || ivl_done;
        spc_inc     = (st_q == ST_SPACE) || ((st_q == ST_GAP) && g);
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (g && cfg_ready) st_d = ST_START;
            ST_START: if (!g) st_d = start_acc ? ST_SPACE : ST_IDLE;
            ST_SPACE: begin
                if (g) begin
                    st_d = ST_GAP;
                end else if (silence_end) begin
                    st_d = ST_IDLE;
                end
            end
            ST_GAP:   if (!g) st_d = ST_SPACE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs and frame status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sof       <= 1'b0;
            bit_valid <= 1'b0;
            bit_data  <= 1'b0;
            frame_end <= 1'b0;
            frame_err <= 1'b0;
            err_q     <= 1'b0;
            fast_q    <= 1'b0;
        end else begin
            sof       <= start_acc;
            bit_valid <= ivl_done && !ivl_bad && !err_q;
            bit_data  <= ivl_done && !ivl_bad && !err_q && (kind == IV_ONE);
            frame_end <= silence_end;
            frame_err <= silence_end && err_q;
            if (start_acc) begin
                fast_q <= fast_mode;
            end
            if (start_acc || silence_end) begin
                err_q <= 1'b0;
            end else if (ivl_bad) begin
                err_q <= 1'b1;
            end
        end
    end

    assign err_flag = err_q;

    AST_SOF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof); // R2
    AST_NO_START_WITHOUT_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && !cfg_ready) |=> (st_q == ST_IDLE)); // R3
    AST_BIT_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> !bit_data); // R4
    AST_NO_BIT_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> !bit_valid); // R7
    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sof, bit_valid, frame_end})); // R8
    AST_FRAME_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> frame_end); // R8
    AST_ERR_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !err_flag); // R8
endmodule

// File: tb/gap_write_decoder_tb.sv
`timescale 1ns/1ps
module gap_write_decoder_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_ready = 1'b0;
    logic fast_mode = 1'b0;
    logic gap_in = 1'b0;
    logic sof, bit_valid, bit_data, frame_end, frame_err, err_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gap_write_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ready(cfg_ready), .fast_mode(fast_mode),
        .gap_in(gap_in), .sof(sof), .bit_valid(bit_valid), .bit_data(bit_data),
        .frame_end(frame_end), .frame_err(frame_err), .err_flag(err_flag)
    );

    // Reference model: timestamps of gap edges, no counters
    logic hist[$];
    int   t = 0;
    bit   m_start, m_frame, m_ingap, m_err, m_fast;
    int   rise_t, last_end;
    bit   e_sof, e_bv, e_bd, e_fe, e_ferr;

    // Observed event tallies
    int          sof_n, bit_n, fe_n, fe_err_n;
    logic [63:0] bits;
    bit          err_seen;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic x);
        int  len, span;
        bit  gok, ok0, ok1;
        e_sof = 0; e_bv = 0; e_bd = 0; e_fe = 0; e_ferr = 0;
        if (!m_frame) begin
            if (!m_start) begin
                if (x && cfg_ready) begin
                    m_start = 1; rise_t = t;
                end
            end else if (!x) begin
                len = t - rise_t;
                m_start = 0;
                if (len >= 10 && len <= 50) begin
                    m_frame = 1; m_ingap = 0; last_end = t;
                    e_sof = 1; m_err = 0; m_fast = fast_mode;
                end
            end
        end else if (m_ingap) begin
            if (!x) begin
                len  = t - rise_t;
                span = t - last_end;
                gok  = (len >= 8) && (len <= (m_fast ? 20 : 30));
                ok0  = m_fast ? (span >= 8 && span <= 15) : (span >= 16 && span <= 31);
                ok1  = m_fast ? (span >= 24 && span <= 31) : (span >= 48 && span <= 63);
                if (!gok || !(ok0 || ok1)) begin
                    m_err = 1;
                end else if (!m_err) begin
                    e_bv = 1; e_bd = ok1;
                end
                m_ingap = 0; last_end = t;
            end
        end else begin
            if (x) begin
                m_ingap = 1; rise_t = t;
            end else if ((t - last_end) >= (m_fast ? 32 : 64)) begin
                e_fe = 1; e_ferr = m_err; m_err = 0; m_frame = 0;
            end
        end
        t++;
    endtask

    task automatic step(input logic v);
        gap_in = v;
        hist.push_back(v);
        @(posedge clk);
        #1;
        model(hist.pop_front());
        chk(sof == e_sof, "R2", "sof", sof, e_sof);
        chk(bit_valid == e_bv, "R4", "bit_valid", bit_valid, e_bv);
        chk(bit_data == e_bd, "R4", "bit_data", bit_data, e_bd);
        chk(frame_end == e_fe, "R8", "frame_end", frame_end, e_fe);
        chk(frame_err == e_ferr, "R8", "frame_err", frame_err, e_ferr);
        chk(err_flag == m_err, "R7", "err_flag", err_flag, m_err);
        if (sof) sof_n++;
        if (bit_valid) begin
            bits = {bits[62:0], bit_data};
            bit_n++;
        end
        if (frame_end) begin
            fe_n++;
            if (frame_err) fe_err_n++;
        end
        if (err_flag) err_seen = 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic sym(input int span, input int glen);
        idle(span - glen);
        gap(glen);
    endtask

    task automatic clear_obs();
        sof_n = 0; bit_n = 0; fe_n = 0; fe_err_n = 0; bits = '0; err_seen = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run incomplete got %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        hist.push_back(1'b0);
        hist.push_back(1'b0);
        clear_obs();
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk({sof, bit_valid, bit_data, frame_end, frame_err, err_flag} == 6'b0,
            "R10", "outputs in reset", {sof, bit_valid, bit_data, frame_end, frame_err, err_flag}, 0);
        rst_n = 1'b1;
        idle(4);
        chk({sof, bit_valid, frame_end, err_flag} == 4'b0, "R10", "outputs after reset",
            {sof, bit_valid, frame_end, err_flag}, 0);

        // R3: configuration not loaded
        gap(20);
        idle(30);
        chk(sof_n == 0, "R3", "sof count without cfg_ready", sof_n, 0);
        cfg_ready = 1'b1;
        idle(5);

        // R2: start gap bounds
        clear_obs();
        gap(9);
        idle(20);
        gap(51);
        idle(20);
        chk(sof_n == 0, "R2", "sof count for 9 and 51 clock gaps", sof_n, 0);
        gap(10);
        step(1'b0);
        chk(sof == 1'b0, "R1", "sof one cycle after low", sof, 0);
        step(1'b0);
        chk(sof == 1'b0, "R1", "sof two cycles after low", sof, 0);
        step(1'b0);
        chk(sof == 1'b1, "R1", "sof three cycles after low", sof, 1);
        idle(80);
        chk(sof_n == 1, "R2", "sof count for 10 clock gap", sof_n, 1);
        chk(fe_n == 1, "R8", "frame end after empty frame", fe_n, 1);
        gap(50);
        idle(80);
        chk(sof_n == 2, "R2", "sof count for 50 clock gap", sof_n, 2);

        // R4 / R9: normal frame on window edges
        clear_obs();
        gap(15);
        sym(24, 10);
        sym(54, 10);
        sym(16, 8);
        sym(31, 8);
        sym(48, 8);
        sym(63, 30);
        sym(50, 10);
        idle(80);
        chk(sof_n == 1, "R2", "sof count normal frame", sof_n, 1);
        chk(bit_n == 7, "R4", "bit count normal frame", bit_n, 7);
        chk(bits[6:0] == 7'b0100111, "R4", "bits normal frame", bits[6:0], 7'b0100111);
        chk(bits[0] == 1'b1, "R9", "40 on + 10 gap decodes as one", bits[0], 1);
        chk(fe_n == 1 && fe_err_n == 0, "R8", "clean frame end", fe_err_n, 0);
        chk(err_seen == 0, "R7", "no error in clean frame", err_seen, 0);

        // R6: write gap too long in normal timing
        clear_obs();
        gap(15);
        sym(24, 10);
        sym(54, 31);
        sym(24, 10);
        idle(80);
        chk(bit_n == 1, "R6", "bits before and after long gap", bit_n, 1);
        chk(fe_err_n == 1, "R6", "frame_err after 31 clock gap", fe_err_n, 1);
        chk(err_seen == 1, "R7", "err_flag raised", err_seen, 1);

        // R7: interval between windows
        clear_obs();
        gap(20);
        sym(40, 10);
        sym(24, 10);
        idle(80);
        chk(bit_n == 0, "R7", "bits after bad interval", bit_n, 0);
        chk(fe_err_n == 1, "R7", "frame_err after bad interval", fe_err_n, 1);

        // R8: 64 field-on clocks keep the frame open
        clear_obs();
        gap(15);
        sym(24, 10);
        idle(64);
        gap(10);
        idle(80);
        chk(fe_n == 1, "R8", "frame ends once after 64 clock silence", fe_n, 1);
        chk(fe_err_n == 1, "R8", "late gap judged inside frame", fe_err_n, 1);
        chk(bit_n == 1, "R8", "bits in boundary frame", bit_n, 1);

        // R5: fast frame, timing latched at acceptance
        fast_mode = 1'b1;
        idle(5);
        clear_obs();
        gap(12);
        sym(12, 8);
        fast_mode = 1'b0;
        sym(15, 8);
        sym(24, 8);
        sym(31, 20);
        idle(32);
        gap(8);
        idle(80);
        chk(bit_n == 4, "R5", "bit count fast frame", bit_n, 4);
        chk(bits[3:0] == 4'b0011, "R5", "bits fast frame", bits[3:0], 4'b0011);
        chk(fe_n == 1 && fe_err_n == 1, "R8", "32 clock silence keeps fast frame", fe_err_n, 1);

        // R6 / R8: fast gap length and fast timeout edge
        fast_mode = 1'b1;
        idle(5);
        clear_obs();
        gap(12);
        sym(24, 8);
        sym(30, 21);
        idle(34);
        chk(fe_n == 0, "R8", "no fast frame end before 33 clocks", fe_n, 0);
        step(1'b0);
        chk(fe_n == 1, "R8", "fast frame end after 33 clocks", fe_n, 1);
        chk(fe_err_n == 1, "R6", "21 clock gap in fast timing", fe_err_n, 1);
        chk(bit_n == 1, "R5", "bits fast error frame", bit_n, 1);
        fast_mode = 1'b0;
        idle(10);

        done = 1'b1;
        finish_run();
    end
endmodule